// File: doc/BRIEF.md
# Serial Bus Master Register Front End

This block is the register-side half of a two-wire serial bus master. Software talks to it through a plain 32-bit register port with separate write and read strobes and a 6-bit byte offset. The block stores the transfer parameters: command code, target register, write data, runtime and hardware device addresses, bit-clock settings, line overrides and device-mode initialisation values. It launches, aborts and completes transfers through a one-cycle handshake with a separate serial bit engine, and it records the outcome in write-one-to-clear status flags that drive a level interrupt.

Three control bits return to zero on their own. The transfer-start bit clears when the engine reports completion or when software aborts. The soft-reset bit clears when the reset acknowledge arrives. The device-mode start bit clears when the initialisation sequence has been sent. While a transfer is in flight, writes to the four transfer-parameter registers are refused and raise a load-busy flag. On a successful read, the received word is loaded into the data register, cut to the width that the command code implies.

Top module: `sbus_regfile`

## Requirements
- R1: `reg_rdata_o` is registered and shows the addressed register one cycle after `reg_rd_i`. After reset, every register reads 0 except device-mode (offset 0x28), which reads 0x007C3E00 (bits 23:16 = 0x7C, bits 15:8 = 0x3E). Unmapped offsets read 0.
- R2: Writing CTRL (0x00) with bit 7 set while idle sets the busy bit (CTRL bit 7) and raises `xfer_start_o` for exactly one cycle. The bit reads 1 until `xfer_done_i`, then 0. CTRL bit 1 is the global interrupt enable.
- R3: A completion without error sets status (0x0C) bit 0. A completion with error sets bit 1, stores `xfer_errbyte_i` in bits 11:8 and `xfer_nack_i` in bit 16.
- R4: Writing 1 to status bits 0..2 clears them and writing 0 leaves them unchanged. Clearing bit 1 also clears bits 11:8 and bit 16. A new event in the same cycle wins over the clear.
- R5: A write to ADDR (0x10), DATA (0x1C), CMD (0x2C) or DAR (0x30) while busy leaves the register unchanged and sets status bit 2.
- R6: `irq_o` equals global enable AND any (status[2:0] AND interrupt-enable (0x08) bits 2:0), registered one cycle after the state it reflects.
- R7: Writing CTRL bit 6 while busy raises `xfer_abort_o` for one cycle and clears busy without setting any status bit. A later `xfer_done_i` is ignored.
- R8: Writing CTRL bit 0 holds `srst_req_o` and CTRL bit 0 high until `srst_done_i`. All registers then return to their reset values.
- R9: Writing device-mode with bit 31 set asserts `dinit_req_o` and drives bits 23:16, 15:8 and 7:0 onto `dinit_data_o`, `dinit_reg_o` and `dinit_dev_o`. Writes to device-mode are ignored while the request is pending. Bit 31 clears on `dinit_done_i`.
- R10: Line control (0x24) bits 0/1 drive the SDA override enable and value, and bits 2/3 drive the SCL override enable and value. Bits 4 and 5 read back `sda_in_i` and `scl_in_i` and are not writable.
- R11: On a successful completion with command 0x8B, 0x9C or 0xA6, DATA is loaded with the low 8, 16 or 32 bits of `xfer_rdata_i`, with the upper bits zero. Other commands and errored completions leave DATA unchanged.
- R12: Clock control (0x04) bits 7:0 drive `clk_div_o` and bits 10:8 drive `sda_dly_o`. Other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_offs_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| xfer_start_o | output | 1 | One-cycle transfer launch |
| xfer_abort_o | output | 1 | One-cycle transfer abort |
| xfer_cmd_o | output | 8 | Command code |
| xfer_reg_o | output | 8 | Target register address |
| xfer_wdata_o | output | 32 | Write data for the engine |
| xfer_rtaddr_o | output | 8 | Runtime device address |
| xfer_hwaddr_o | output | 16 | Hardware device address |
| xfer_done_i | input | 1 | Engine completion pulse |
| xfer_err_i | input | 1 | Completion carries an error |
| xfer_nack_i | input | 1 | Acknowledge error detail |
| xfer_errbyte_i | input | 4 | Failing data byte detail |
| xfer_rdata_i | input | 32 | Received data |
| srst_req_o | output | 1 | Soft reset request |
| srst_done_i | input | 1 | Soft reset acknowledge |
| dinit_req_o | output | 1 | Device-mode initialisation request |
| dinit_data_o | output | 8 | Initialisation data value |
| dinit_reg_o | output | 8 | Initialisation register value |
| dinit_dev_o | output | 8 | Initialisation device address |
| dinit_done_i | input | 1 | Initialisation sent |
| clk_div_o | output | 8 | Bit-clock divider |
| sda_dly_o | output | 3 | SDA output delay |
| sda_ovr_en_o | output | 1 | SDA override enable |
| sda_ovr_val_o | output | 1 | SDA override value |
| scl_ovr_en_o | output | 1 | SCL override enable |
| scl_ovr_val_o | output | 1 | SCL override value |
| sda_in_i | input | 1 | SDA line state |
| scl_in_i | input | 1 | SCL line state |

## Verification
The assertions assume the following about the handshake inputs:
- `xfer_done_i` and its detail inputs are single-cycle pulses.
- `srst_done_i` and `dinit_done_i` arrive only while the matching request is raised.
- The register port never writes and reads in the same cycle.

The stimulus keeps to these rules. Every completion, acknowledge and register access is issued by a task that drives a single one-cycle strobe on a falling edge. Completions are issued only after a launch, except in the abort test, which sends one on purpose to show that it is ignored.

// File: rtl/sbus_regfile_pkg.sv
package sbus_regfile_pkg;

  localparam int OFFS_W = 6;
  localparam int NSTS   = 3;

  localparam logic [OFFS_W-1:0] OFS_CTRL  = 6'h00;
  localparam logic [OFFS_W-1:0] OFS_CLK   = 6'h04;
  localparam logic [OFFS_W-1:0] OFS_IEN   = 6'h08;
  localparam logic [OFFS_W-1:0] OFS_IST   = 6'h0C;
  localparam logic [OFFS_W-1:0] OFS_ADDR  = 6'h10;
  localparam logic [OFFS_W-1:0] OFS_DATA  = 6'h1C;
  localparam logic [OFFS_W-1:0] OFS_LINE  = 6'h24;
  localparam logic [OFFS_W-1:0] OFS_DMODE = 6'h28;
  localparam logic [OFFS_W-1:0] OFS_CMD   = 6'h2C;
  localparam logic [OFFS_W-1:0] OFS_DEV   = 6'h30;

  localparam logic [7:0] CMD_RD8  = 8'h8B;
  localparam logic [7:0] CMD_RD16 = 8'h9C;
  localparam logic [7:0] CMD_RD32 = 8'hA6;

  localparam logic [7:0] DM_DATA_RST = 8'h7C;
  localparam logic [7:0] DM_REG_RST  = 8'h3E;

  typedef struct packed {
    logic ctrl;
    logic clk;
    logic ien;
    logic ist;
    logic addr;
    logic data;
    logic line;
    logic dmode;
    logic cmd;
    logic dev;
  } wsel_t;

  function automatic wsel_t decode_offset(input logic [OFFS_W-1:0] o);
    wsel_t s;
    s       = '0;
    s.ctrl  = (o == OFS_CTRL);
    s.clk   = (o == OFS_CLK);
    s.ien   = (o == OFS_IEN);
    s.ist   = (o == OFS_IST);
    s.addr  = (o == OFS_ADDR);
    s.data  = (o == OFS_DATA);
    s.line  = (o == OFS_LINE);
    s.dmode = (o == OFS_DMODE);
    s.cmd   = (o == OFS_CMD);
    s.dev   = (o == OFS_DEV);
    return s;
  endfunction

  function automatic logic [31:0] read_mask(input logic [7:0] c);
    logic [31:0] m;
    case (c)
      CMD_RD8:  m = 32'h0000_00FF;
      CMD_RD16: m = 32'h0000_FFFF;
      CMD_RD32: m = 32'hFFFF_FFFF;
      default:  m = 32'h0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sbus_ctrl_unit.sv
module sbus_ctrl_unit
  import sbus_regfile_pkg::*;
#(
  parameter int DM_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_ctrl,
  input  logic            w_start,
  input  logic            w_abort,
  input  logic            w_gie,
  input  logic            w_srst,
  input  logic            we_dmode,
  input  logic            w_dm_go,
  input  logic [DM_W-1:0] w_dm_data,
  input  logic [DM_W-1:0] w_dm_reg,
  input  logic [DM_W-1:0] w_dm_dev,
  input  logic            xfer_end,
  input  logic            srst_done_i,
  input  logic            dinit_done_i,
  output logic            busy,
  output logic            gie,
  output logic            srst_q,
  output logic            start_pulse,
  output logic            abort_pulse,
  output logic            dinit_q,
  output logic [DM_W-1:0] dm_data,
  output logic [DM_W-1:0] dm_reg,
  output logic [DM_W-1:0] dm_dev,
  output logic            soft_clr
);

  assign soft_clr = srst_q & srst_done_i;

  // Start, abort, enable and soft reset
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      busy        <= 1'b0;
      gie         <= 1'b0;
      srst_q      <= 1'b0;
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
      if (busy && xfer_end) busy <= 1'b0;
      if (we_ctrl) begin
        gie <= w_gie;
        if (w_srst) srst_q <= 1'b1;
        if (w_start && !busy) begin
          busy        <= 1'b1;
          start_pulse <= 1'b1;
        end else if (w_abort && busy && !xfer_end) begin
          busy        <= 1'b0;
          abort_pulse <= 1'b1;
        end
      end
    end
  end

  // Device-mode initialisation request
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      dinit_q <= 1'b0;
      dm_data <= DM_DATA_RST;
      dm_reg  <= DM_REG_RST;
      dm_dev  <= '0;
    end else if (dinit_q) begin
      if (dinit_done_i) dinit_q <= 1'b0;
    end else if (we_dmode) begin
      dinit_q <= w_dm_go;
      dm_data <= w_dm_data;
      dm_reg  <= w_dm_reg;
      dm_dev  <= w_dm_dev;
    end
  end

  assert_launch_once_R2: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> busy);
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> !busy);
  assert_srst_clear_R8: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (!srst_q && !busy && !gie));
  assert_dinit_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (dinit_q && dinit_done_i) |=> !dinit_q);

endmodule

// File: rtl/sbus_stat_unit.sv
module sbus_stat_unit
  import sbus_regfile_pkg::*;
#(
  parameter int ERRB_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_clr,
  input  logic              we_ist,
  input  logic [NSTS-1:0]   w_clr,
  input  logic              we_ien,
  input  logic [NSTS-1:0]   w_ien,
  input  logic              xfer_end,
  input  logic              xfer_err,
  input  logic              xfer_nack,
  input  logic [ERRB_W-1:0] err_byte,
  input  logic              lbusy_evt,
  input  logic              gie,
  output logic [NSTS-1:0]   sts_q,
  output logic [ERRB_W-1:0] errb_q,
  output logic              nack_q,
  output logic [NSTS-1:0]   ien_q,
  output logic              irq_o
);

  logic [NSTS-1:0] sts_set;
  logic [NSTS-1:0] sts_clr;

  assign sts_set = {lbusy_evt, xfer_end & xfer_err, xfer_end & ~xfer_err};
  assign sts_clr = we_ist ? w_clr : '0;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      sts_q  <= '0;
      errb_q <= '0;
      nack_q <= 1'b0;
      ien_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (sts_set[1]) begin
        errb_q <= err_byte;
        nack_q <= xfer_nack;
      end else if (sts_clr[1]) begin
        errb_q <= '0;
        nack_q <= 1'b0;
      end
      if (we_ien) ien_q <= w_ien;
      irq_o <= gie & (|(sts_q & ien_q));
    end
  end

  assert_over_set_R3: assert property (@(posedge clk) disable iff (rst || soft_clr)
    (xfer_end && !xfer_err) |=> sts_q[0]);
  assert_err_set_R3: assert property (@(posedge clk) disable iff (rst || soft_clr)
    (xfer_end && xfer_err) |=> sts_q[1]);
  assert_w1c_over_R4: assert property (@(posedge clk) disable iff (rst || soft_clr)
    (we_ist && w_clr[0] && !xfer_end) |=> !sts_q[0]);
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(gie) |-> !irq_o);

endmodule

// File: rtl/sbus_cfg_regs.sv
module sbus_cfg_regs
  import sbus_regfile_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 8,
  parameter int DLY_W = 3,
  parameter int RT_W  = 8,
  parameter int HW_W  = 16,
  parameter int LN_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr,
  input  logic             busy,
  input  logic             we_clk,
  input  logic             we_addr,
  input  logic             we_data,
  input  logic             we_line,
  input  logic             we_cmd,
  input  logic             we_dev,
  input  logic [DW-1:0]    wdata,
  input  logic             xfer_ok,
  input  logic [DW-1:0]    xfer_rdata,
  output logic             lbusy_evt,
  output logic [DIV_W-1:0] div_q,
  output logic [DLY_W-1:0] dly_q,
  output logic [7:0]       addr_q,
  output logic [DW-1:0]    data_q,
  output logic [LN_W-1:0]  line_q,
  output logic [7:0]       cmd_q,
  output logic [RT_W-1:0]  rt_q,
  output logic [HW_W-1:0]  hw_q
);

  localparam int DLY_LSB = DIV_W;
  localparam int RT_LSB  = HW_W;

  logic [DW-1:0] rmask;
  logic          rd_load;

  assign lbusy_evt = busy & (we_addr | we_data | we_cmd | we_dev);
  assign rmask     = DW'(read_mask(cmd_q));
  assign rd_load   = xfer_ok & (|rmask);

  // Transfer parameters, locked while busy
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      addr_q <= '0;
      cmd_q  <= '0;
      rt_q   <= '0;
      hw_q   <= '0;
    end else if (!busy) begin
      if (we_addr) addr_q <= wdata[7:0];
      if (we_cmd)  cmd_q  <= wdata[7:0];
      if (we_dev) begin
        rt_q <= wdata[RT_LSB +: RT_W];
        hw_q <= wdata[HW_W-1:0];
      end
    end
  end

  // Data word: written by software when idle, loaded by reads
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      data_q <= '0;
    end else if (rd_load) begin
      data_q <= xfer_rdata & rmask;
    end else if (we_data && !busy) begin
      data_q <= wdata;
    end
  end

  // Clock and line control, always writable
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      div_q  <= '0;
      dly_q  <= '0;
      line_q <= '0;
    end else begin
      if (we_clk) begin
        div_q <= wdata[DIV_W-1:0];
        dly_q <= wdata[DLY_LSB +: DLY_W];
      end
      if (we_line) line_q <= wdata[LN_W-1:0];
    end
  end

  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst || soft_clr)
    (we_cmd && busy) |=> $stable(cmd_q));
  assert_dev_hold_R5: assert property (@(posedge clk) disable iff (rst || soft_clr)
    (we_dev && busy) |=> ($stable(rt_q) && $stable(hw_q)));
  assert_rd8_width_R11: assert property (@(posedge clk) disable iff (rst || soft_clr)
    (xfer_ok && cmd_q == CMD_RD8) |=> (data_q[DW-1:8] == '0));

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_regfile_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ERRB_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [OFFS_W-1:0] reg_offs_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              xfer_start_o,
  output logic              xfer_abort_o,
  output logic [7:0]        xfer_cmd_o,
  output logic [7:0]        xfer_reg_o,
  output logic [DW-1:0]     xfer_wdata_o,
  output logic [7:0]        xfer_rtaddr_o,
  output logic [15:0]       xfer_hwaddr_o,
  input  logic              xfer_done_i,
  input  logic              xfer_err_i,
  input  logic              xfer_nack_i,
  input  logic [ERRB_W-1:0] xfer_errbyte_i,
  input  logic [DW-1:0]     xfer_rdata_i,
  output logic              srst_req_o,
  input  logic              srst_done_i,
  output logic              dinit_req_o,
  output logic [7:0]        dinit_data_o,
  output logic [7:0]        dinit_reg_o,
  output logic [7:0]        dinit_dev_o,
  input  logic              dinit_done_i,
  output logic [7:0]        clk_div_o,
  output logic [2:0]        sda_dly_o,
  output logic              sda_ovr_en_o,
  output logic              sda_ovr_val_o,
  output logic              scl_ovr_en_o,
  output logic              scl_ovr_val_o,
  input  logic              sda_in_i,
  input  logic              scl_in_i
);

  localparam int DM_W  = 8;
  localparam int DIV_W = 8;
  localparam int DLY_W = 3;
  localparam int LN_W  = 4;

  wsel_t sel;
  wsel_t we;

  assign sel = decode_offset(reg_offs_i);
  assign we  = reg_wr_i ? sel : '0;

  logic busy, gie, srst_q, dinit_q, soft_clr, lbusy_evt, xfer_end;
  logic [DM_W-1:0]   dm_data, dm_reg, dm_dev;
  logic [NSTS-1:0]   sts_q, ien_q;
  logic [ERRB_W-1:0] errb_q;
  logic              nack_q;
  logic [DIV_W-1:0]  div_q;
  logic [DLY_W-1:0]  dly_q;
  logic [7:0]        addr_q, cmd_q, rt_q;
  logic [15:0]       hw_q;
  logic [DW-1:0]     data_q;
  logic [LN_W-1:0]   line_q;

  assign xfer_end = xfer_done_i & busy;

  sbus_ctrl_unit #(.DM_W(DM_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .we_ctrl      (we.ctrl),
    .w_start      (reg_wdata_i[7]),
    .w_abort      (reg_wdata_i[6]),
    .w_gie        (reg_wdata_i[1]),
    .w_srst       (reg_wdata_i[0]),
    .we_dmode     (we.dmode),
    .w_dm_go      (reg_wdata_i[31]),
    .w_dm_data    (reg_wdata_i[23:16]),
    .w_dm_reg     (reg_wdata_i[15:8]),
    .w_dm_dev     (reg_wdata_i[7:0]),
    .xfer_end     (xfer_end),
    .srst_done_i  (srst_done_i),
    .dinit_done_i (dinit_done_i),
    .busy         (busy),
    .gie          (gie),
    .srst_q       (srst_q),
    .start_pulse  (xfer_start_o),
    .abort_pulse  (xfer_abort_o),
    .dinit_q      (dinit_q),
    .dm_data      (dm_data),
    .dm_reg       (dm_reg),
    .dm_dev       (dm_dev),
    .soft_clr     (soft_clr)
  );

  sbus_stat_unit #(.ERRB_W(ERRB_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (soft_clr),
    .we_ist    (we.ist),
    .w_clr     (reg_wdata_i[NSTS-1:0]),
    .we_ien    (we.ien),
    .w_ien     (reg_wdata_i[NSTS-1:0]),
    .xfer_end  (xfer_end),
    .xfer_err  (xfer_err_i),
    .xfer_nack (xfer_nack_i),
    .err_byte  (xfer_errbyte_i),
    .lbusy_evt (lbusy_evt),
    .gie       (gie),
    .sts_q     (sts_q),
    .errb_q    (errb_q),
    .nack_q    (nack_q),
    .ien_q     (ien_q),
    .irq_o     (irq_o)
  );

  sbus_cfg_regs #(
    .DW(DW), .DIV_W(DIV_W), .DLY_W(DLY_W), .RT_W(8), .HW_W(16), .LN_W(LN_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .soft_clr   (soft_clr),
    .busy       (busy),
    .we_clk     (we.clk),
    .we_addr    (we.addr),
    .we_data    (we.data),
    .we_line    (we.line),
    .we_cmd     (we.cmd),
    .we_dev     (we.dev),
    .wdata      (reg_wdata_i),
    .xfer_ok    (xfer_end & ~xfer_err_i),
    .xfer_rdata (xfer_rdata_i),
    .lbusy_evt  (lbusy_evt),
    .div_q      (div_q),
    .dly_q      (dly_q),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .line_q     (line_q),
    .cmd_q      (cmd_q),
    .rt_q       (rt_q),
    .hw_q       (hw_q)
  );

  // Read multiplexer
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.ctrl:  rd_mux = DW'({busy, 5'b0, gie, srst_q});
      sel.clk:   rd_mux = DW'({dly_q, div_q});
      sel.ien:   rd_mux = DW'(ien_q);
      sel.ist:   rd_mux = DW'({nack_q, 4'b0, errb_q, 5'b0, sts_q});
      sel.addr:  rd_mux = DW'(addr_q);
      sel.data:  rd_mux = data_q;
      sel.line:  rd_mux = DW'({scl_in_i, sda_in_i, line_q});
      sel.dmode: rd_mux = DW'({dinit_q, 7'b0, dm_data, dm_reg, dm_dev});
      sel.cmd:   rd_mux = DW'(cmd_q);
      sel.dev:   rd_mux = DW'({rt_q, hw_q});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  assign xfer_cmd_o    = cmd_q;
  assign xfer_reg_o    = addr_q;
  assign xfer_wdata_o  = data_q;
  assign xfer_rtaddr_o = rt_q;
  assign xfer_hwaddr_o = hw_q;
  assign srst_req_o    = srst_q;
  assign dinit_req_o   = dinit_q;
  assign dinit_data_o  = dm_data;
  assign dinit_reg_o   = dm_reg;
  assign dinit_dev_o   = dm_dev;
  assign clk_div_o     = div_q;
  assign sda_dly_o     = dly_q;
  assign sda_ovr_en_o  = line_q[0];
  assign sda_ovr_val_o = line_q[1];
  assign scl_ovr_en_o  = line_q[2];
  assign scl_ovr_val_o = line_q[3];

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> $stable(reg_rdata_o));

endmodule

// File: tb/sbus_regfile_test.sv
module sbus_regfile_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_wr_i = 0, reg_rd_i = 0;
  logic [5:0]  reg_offs_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        irq_o, xfer_start_o, xfer_abort_o;
  logic [7:0]  xfer_cmd_o, xfer_reg_o, xfer_rtaddr_o;
  logic [31:0] xfer_wdata_o;
  logic [15:0] xfer_hwaddr_o;
  logic        xfer_done_i = 0, xfer_err_i = 0, xfer_nack_i = 0;
  logic [3:0]  xfer_errbyte_i = '0;
  logic [31:0] xfer_rdata_i = '0;
  logic        srst_req_o, srst_done_i = 0;
  logic        dinit_req_o, dinit_done_i = 0;
  logic [7:0]  dinit_data_o, dinit_reg_o, dinit_dev_o, clk_div_o;
  logic [2:0]  sda_dly_o;
  logic        sda_ovr_en_o, sda_ovr_val_o, scl_ovr_en_o, scl_ovr_val_o;
  logic        sda_in_i = 1'b1, scl_in_i = 1'b0;

  sbus_regfile uut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [31:0] rv;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] o, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1; reg_offs_i = o; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 0;
  endtask

  task automatic rd(input logic [5:0] o, output logic [31:0] d);
    @(negedge clk);
    reg_rd_i = 1; reg_offs_i = o;
    @(negedge clk);
    reg_rd_i = 0;
    d = reg_rdata_o;
  endtask

  task automatic engine_end(input logic e, input logic n, input logic [3:0] b,
                            input logic [31:0] r);
    @(negedge clk);
    xfer_done_i = 1; xfer_err_i = e; xfer_nack_i = n; xfer_errbyte_i = b; xfer_rdata_i = r;
    @(negedge clk);
    xfer_done_i = 0; xfer_err_i = 0; xfer_nack_i = 0; xfer_errbyte_i = '0;
  endtask

  // error transfer, ok transfer, refused write: status = 0x0001_0A07
  task automatic load_all_status();
    wr(6'h0C, 32'h7);
    wr(6'h2C, 32'h4E);
    wr(6'h00, 32'h80);
    engine_end(1, 1, 4'hA, 0);
    wr(6'h00, 32'h80);
    wr(6'h30, 32'h0);
    engine_end(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset values, R10 line state readback
    rd(6'h00, rv); check("R1 ctrl", rv, 0);
    rd(6'h04, rv); check("R1 clk", rv, 0);
    rd(6'h08, rv); check("R1 ien", rv, 0);
    rd(6'h0C, rv); check("R1 ist", rv, 0);
    rd(6'h10, rv); check("R1 addr", rv, 0);
    rd(6'h1C, rv); check("R1 data", rv, 0);
    rd(6'h24, rv); check("R10 line reset", rv, 32'h10);
    rd(6'h28, rv); check("R1 dmode", rv, 32'h007C3E00);
    rd(6'h2C, rv); check("R1 cmd", rv, 0);
    rd(6'h30, rv); check("R1 dev", rv, 0);
    rd(6'h14, rv); check("R1 unmapped", rv, 0);
    check("R1 irq", irq_o, 0);

    // R12 clock control
    wr(6'h04, 32'hFFFF_FD5A);
    check("R12 div", clk_div_o, 8'h5A);
    check("R12 dly", sda_dly_o, 3'd5);
    rd(6'h04, rv); check("R12 readback", rv, 32'h55A);

    // R10 line override sweep
    for (int v = 0; v < 16; v++) begin
      sda_in_i = v[1]; scl_in_i = v[2];
      wr(6'h24, 32'(v) | 32'hF0);
      check("R10 ovr", {28'h0, scl_ovr_val_o, scl_ovr_en_o, sda_ovr_val_o, sda_ovr_en_o}, 32'(v));
      rd(6'h24, rv);
      check("R10 read", rv, {26'h0, v[2], v[1], 4'(v)});
    end

    // R2 launch, R5 refused writes, R3 completion
    wr(6'h08, 32'h7);
    wr(6'h10, 32'h5A);
    wr(6'h1C, 32'h1234_5678);
    wr(6'h30, 32'h002D_03A3);
    wr(6'h2C, 32'h4E);
    wr(6'h00, 32'h82);
    check("R2 start pulse", xfer_start_o, 1);
    check("R2 params", {xfer_cmd_o, xfer_reg_o, xfer_rtaddr_o}, 32'h4E5A2D);
    check("R2 hw addr", xfer_hwaddr_o, 16'h03A3);
    check("R2 wdata", xfer_wdata_o, 32'h1234_5678);
    @(negedge clk);
    check("R2 pulse width", xfer_start_o, 0);
    rd(6'h00, rv); check("R2 busy", rv, 32'h82);
    wr(6'h2C, 32'h11);
    rd(6'h2C, rv); check("R5 cmd held", rv, 32'h4E);
    wr(6'h1C, 32'h0);
    rd(6'h1C, rv); check("R5 data held", rv, 32'h1234_5678);
    rd(6'h0C, rv); check("R5 load busy", rv, 32'h4);
    engine_end(0, 0, 0, 32'hFFFF_FFFF);
    rd(6'h0C, rv); check("R3 over", rv, 32'h5);
    rd(6'h00, rv); check("R2 busy clears", rv, 32'h02);
    rd(6'h1C, rv); check("R11 write cmd keeps data", rv, 32'h1234_5678);
    check("R6 irq on", irq_o, 1);
    wr(6'h0C, 32'h7);
    rd(6'h0C, rv); check("R4 all cleared", rv, 0);
    check("R6 irq off", irq_o, 0);

    // R4 W1C sweep
    for (int m = 0; m < 8; m++) begin
      load_all_status();
      rd(6'h0C, rv); check("R3 error detail", rv, 32'h0001_0A07);
      wr(6'h0C, 32'(m) | 32'h0001_0F00);
      rd(6'h0C, rv);
      check("R4 w1c", rv, (32'h7 & ~32'(m)) | (m[1] ? 32'h0 : 32'h0001_0A00));
    end

    // R6 interrupt sweep
    for (int p = 0; p < 2; p++) begin
      load_all_status();
      if (p == 1) wr(6'h0C, 32'h6);
      for (int g = 0; g < 2; g++) begin
        for (int e = 0; e < 8; e++) begin
          wr(6'h00, 32'(g) << 1);
          wr(6'h08, 32'(e));
          @(negedge clk);
          check("R6 irq", irq_o, (g == 1) && ((e & (p == 1 ? 1 : 7)) != 0));
        end
      end
    end

    // R11 read width loading
    wr(6'h0C, 32'h7);
    wr(6'h1C, 32'hCAFE_F00D);
    wr(6'h2C, 32'h4E); wr(6'h00, 32'h80); engine_end(0, 0, 0, 32'hDEAD_BEEF);
    rd(6'h1C, rv); check("R11 write cmd", rv, 32'hCAFE_F00D);
    wr(6'h2C, 32'h8B); wr(6'h00, 32'h80); engine_end(0, 0, 0, 32'hDEAD_BEEF);
    rd(6'h1C, rv); check("R11 read8", rv, 32'hEF);
    wr(6'h2C, 32'h9C); wr(6'h00, 32'h80); engine_end(0, 0, 0, 32'hDEAD_BEEF);
    rd(6'h1C, rv); check("R11 read16", rv, 32'hBEEF);
    wr(6'h2C, 32'hA6); wr(6'h00, 32'h80); engine_end(0, 0, 0, 32'hDEAD_BEEF);
    rd(6'h1C, rv); check("R11 read32", rv, 32'hDEAD_BEEF);
    wr(6'h2C, 32'h8B); wr(6'h00, 32'h80); engine_end(1, 0, 4'h3, 32'h11);
    rd(6'h1C, rv); check("R11 error keeps", rv, 32'hDEAD_BEEF);

    // R7 abort
    wr(6'h0C, 32'h7);
    wr(6'h2C, 32'h4E);
    wr(6'h00, 32'h80);
    wr(6'h00, 32'hC0);
    check("R7 abort pulse", xfer_abort_o, 1);
    check("R7 no relaunch", xfer_start_o, 0);
    rd(6'h00, rv); check("R7 busy cleared", rv, 0);
    check("R7 abort width", xfer_abort_o, 0);
    engine_end(0, 0, 0, 0);
    rd(6'h0C, rv); check("R7 no status", rv, 0);

    // R9 device-mode initialisation
    wr(6'h28, 32'h8012_3456);
    check("R9 req", dinit_req_o, 1);
    check("R9 fields", {8'h0, dinit_data_o, dinit_reg_o, dinit_dev_o}, 32'h123456);
    wr(6'h28, 32'h00FF_FFFF);
    rd(6'h28, rv); check("R9 locked", rv, 32'h8012_3456);
    @(negedge clk); dinit_done_i = 1;
    @(negedge clk); dinit_done_i = 0;
    rd(6'h28, rv); check("R9 self clear", rv, 32'h0012_3456);
    check("R9 req drop", dinit_req_o, 0);

    // R8 soft reset
    wr(6'h08, 32'h5);
    wr(6'h04, 32'h123);
    wr(6'h00, 32'h03);
    check("R8 req", srst_req_o, 1);
    rd(6'h00, rv); check("R8 bit held", rv, 32'h03);
    @(negedge clk); srst_done_i = 1;
    @(negedge clk); srst_done_i = 0;
    check("R8 req drop", srst_req_o, 0);
    rd(6'h00, rv); check("R8 ctrl", rv, 0);
    rd(6'h08, rv); check("R8 ien", rv, 0);
    rd(6'h04, rv); check("R8 clk", rv, 0);
    rd(6'h28, rv); check("R8 dmode", rv, 32'h007C3E00);
    rd(6'h1C, rv); check("R8 data", rv, 0);

    summary();
    $finish;
  end

endmodule